// File: doc/BRIEF.md
# Self-Invalidating Private Data Cache Controller

This block is the controller of one core's private data cache in a multicore system where coherence is kept without a directory and without broadcast. Every line carries a private/shared tag taken from a classification bit that travels with each core request. Private lines use write-back: stores stay in the cache and reach the shared lower level only when the line is evicted. Shared lines use write-through: every store is forwarded to the lower level at once, so a shared line is never dirty.

Nothing arrives from other cores. Shared data written elsewhere becomes visible when the core signals a synchronization point: the controller then walks every set, one per cycle, and drops each valid shared line while private lines stay. The cache is direct-mapped with one data word per line. At most one lower-level transaction is in flight, and the core port stalls until it completes.

Top module: `sinv_dcache`

## Requirements
- R1: After reset every line is invalid, req_ready_o is 1, busy_o is 0, and neither mem_req_valid_o nor rsp_valid_o is asserted.
- R2: A load to a resident line whose stored classification equals req_shared_i returns the cached word and issues no lower-level transaction.
- R3: A load that misses issues exactly one lower-level read of the requested word address, installs the line with the request's classification and returns the read data.
- R4: A store with req_shared_i=0 issues no lower-level transaction when the set holds no dirty line of another address. The line is written and marked dirty, and it is allocated on a miss (write-allocate).
- R5: A load miss or a private store miss whose set holds a valid dirty line first writes that line back to its own address with its data. Only then does a load issue its fill read.
- R6: A store with req_shared_i=1 issues exactly one lower-level write with the store's address and data. A resident shared copy is updated. A miss allocates nothing. A shared line is never dirty, so evicting it causes no write-back.
- R7: After a sync pulse every valid shared line is invalid, and the next load of it fetches from the lower level. Private lines, dirty or clean, keep their state and data.
- R8: A sync pulse on sync_i raises busy_o for exactly SETS cycles when the controller is idle. A sync that arrives during a request is held and runs once the request finishes. No core request is accepted while busy_o is 1.
- R9: A request whose classification differs from that of the resident line of the same address first writes that line back if it is dirty. The line is then dropped and the request proceeds as a miss.
- R10: At most one lower-level request is outstanding. mem_req_valid_o, address, write flag and data stay stable until mem_rsp_valid_i.
- R11: Each accepted request gets exactly one single-cycle rsp_valid_o pulse. For a load, rsp_rdata_o carries the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Core request accepted this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_shared_i | input | 1 | Classification: 1 = shared, 0 = private |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Request completed (one-cycle pulse) |
| rsp_rdata_o | output | DATA_W | Load data |
| sync_i | input | 1 | Synchronization pulse |
| busy_o | output | 1 | Self-invalidation pending or in progress |
| mem_req_valid_o | output | 1 | Lower-level request valid, held until response |
| mem_req_write_o | output | 1 | Lower-level request is a write |
| mem_req_addr_o | output | ADDR_W | Lower-level word address |
| mem_req_wdata_o | output | DATA_W | Lower-level write data |
| mem_rsp_valid_i | input | 1 | Lower-level response / completion |
| mem_rsp_rdata_i | input | DATA_W | Lower-level read data |

## Verification
Directed sequences on one set tell the two write policies apart. A private store followed by a conflicting load must show a write-back then a fill in that order. A shared store must show an immediate write and later evict with no write-back. Another agent's update to a shared word is first read back stale, then fresh after a sync. This separates self-invalidation from remote invalidation and shows that private lines survive the walk. Mixed random loads, stores, foreign writes and syncs, each address with a fixed classification, are checked against a bench model of the core's view of memory. A flipped classification on a dirty line checks the drop-and-refetch path.

// File: rtl/sinv_pkg.sv
package sinv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_WT,
    ST_WALK
  } ctrl_state_e;
endpackage

// File: rtl/sinv_tag_array.sv
module sinv_tag_array #(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic             rd_shared_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             we_i,
  input  logic             wvalid_i,
  input  logic             wdirty_i,
  input  logic             wshared_i,
  input  logic [TAG_W-1:0] wtag_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  logic [SETS-1:0]  valid_q, dirty_q, shared_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign rd_valid_o  = valid_q[idx_i];
  assign rd_dirty_o  = dirty_q[idx_i];
  assign rd_shared_o = shared_q[idx_i];
  assign rd_tag_o    = tag_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      dirty_q  <= '0;
      shared_q <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else if (clr_i) begin
      // self-invalidate: drop only shared lines
      valid_q[clr_idx_i] <= valid_q[clr_idx_i] & ~shared_q[clr_idx_i];
    end else if (we_i) begin
      valid_q[idx_i]  <= wvalid_i;
      dirty_q[idx_i]  <= wdirty_i;
      shared_q[idx_i] <= wshared_i;
      tag_q[idx_i]    <= wtag_i;
    end
  end

  for (genvar g = 0; g < SETS; g++) begin : g_set_chk
    // R6
    no_dirty_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[g] && shared_q[g]) |-> !dirty_q[g]);
  end

  // R7
  walk_clears_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_idx_i == IDX_W'(SETS - 1)) |=> ((valid_q & shared_q) == '0));
endmodule

// File: rtl/sinv_data_store.sv
module sinv_data_store #(
  parameter int SETS   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [SETS];

  assign rdata_o = mem_q[idx_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end
endmodule

// File: rtl/sinv_ctrl.sv
module sinv_ctrl
  import sinv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_shared_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              sync_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              t_valid_i,
  input  logic              t_dirty_i,
  input  logic              t_shared_i,
  input  logic [TAG_W-1:0]  t_tag_i,
  output logic              t_we_o,
  output logic              t_wvalid_o,
  output logic              t_wdirty_o,
  output logic              t_wshared_o,
  output logic [TAG_W-1:0]  t_wtag_o,
  output logic              t_clr_o,
  output logic [IDX_W-1:0]  t_clr_idx_o,
  output logic              d_we_o,
  output logic [DATA_W-1:0] d_wdata_o,
  input  logic [DATA_W-1:0] d_rdata_i
);
  ctrl_state_e state_q, state_d;
  logic              q_write, q_shared;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              sync_pend_q;
  logic [IDX_W-1:0]  walk_idx_q;
  logic              rsp_set;
  logic [DATA_W-1:0] rsp_data;
  logic              tag_hit;

  wire [IDX_W-1:0] q_idx = q_addr[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag = q_addr[ADDR_W-1:IDX_W];

  assign idx_o       = q_idx;
  assign tag_hit     = t_valid_i && (t_tag_i == q_tag);
  assign req_ready_o = (state_q == ST_IDLE) && !sync_i && !sync_pend_q;
  assign busy_o      = sync_pend_q || (state_q == ST_WALK);

  always_comb begin
    state_d         = state_q;
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = q_addr;
    mem_req_wdata_o = q_wdata;
    t_we_o          = 1'b0;
    t_wvalid_o      = 1'b0;
    t_wdirty_o      = 1'b0;
    t_wshared_o     = 1'b0;
    t_wtag_o        = q_tag;
    t_clr_o         = 1'b0;
    t_clr_idx_o     = walk_idx_q;
    d_we_o          = 1'b0;
    d_wdata_o       = q_wdata;
    rsp_set         = 1'b0;
    rsp_data        = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sync_i || sync_pend_q) state_d = ST_WALK;
        else if (req_valid_i)      state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (tag_hit && (t_shared_i != q_shared)) begin
          // classification changed: flush if dirty, then drop and retry
          if (t_dirty_i) state_d = ST_WB;
          else begin
            t_we_o   = 1'b1;
            t_wtag_o = t_tag_i;
          end
        end else if (q_write && q_shared) begin
          d_we_o  = tag_hit;
          state_d = ST_WT;
        end else if (q_write) begin
          if (!tag_hit && t_valid_i && t_dirty_i) state_d = ST_WB;
          else begin
            t_we_o     = 1'b1;
            t_wvalid_o = 1'b1;
            t_wdirty_o = 1'b1;
            d_we_o     = 1'b1;
            rsp_set    = 1'b1;
            state_d    = ST_IDLE;
          end
        end else if (tag_hit) begin
          rsp_set  = 1'b1;
          rsp_data = d_rdata_i;
          state_d  = ST_IDLE;
        end else if (t_valid_i && t_dirty_i) begin
          state_d = ST_WB;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = {t_tag_i, q_idx};
        mem_req_wdata_o = d_rdata_i;
        if (mem_rsp_valid_i) begin
          t_we_o   = 1'b1;
          t_wtag_o = t_tag_i;
          state_d  = ST_LOOK;
        end
      end
      ST_FILL: begin
        mem_req_valid_o = 1'b1;
        if (mem_rsp_valid_i) begin
          t_we_o      = 1'b1;
          t_wvalid_o  = 1'b1;
          t_wshared_o = q_shared;
          d_we_o      = 1'b1;
          d_wdata_o   = mem_rsp_rdata_i;
          rsp_set     = 1'b1;
          rsp_data    = mem_rsp_rdata_i;
          state_d     = ST_IDLE;
        end
      end
      ST_WT: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        if (mem_rsp_valid_i) begin
          rsp_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WALK: begin
        t_clr_o = 1'b1;
        if (walk_idx_q == IDX_W'(SETS - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      q_write     <= 1'b0;
      q_shared    <= 1'b0;
      q_addr      <= '0;
      q_wdata     <= '0;
      sync_pend_q <= 1'b0;
      walk_idx_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_set;
      if (rsp_set) rsp_rdata_o <= rsp_data;
      if (state_q == ST_IDLE && state_d == ST_WALK) begin
        sync_pend_q <= 1'b0;
        walk_idx_q  <= '0;
      end else begin
        if (sync_i) sync_pend_q <= 1'b1;
        if (state_q == ST_WALK) walk_idx_q <= walk_idx_q + 1'b1;
      end
      if (req_valid_i && req_ready_o) begin
        q_write  <= req_write_i;
        q_shared <= req_shared_i;
        q_addr   <= req_addr_i;
        q_wdata  <= req_wdata_i;
      end
    end
  end

  // R10
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_rsp_valid_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)
       && $stable(mem_req_wdata_o)));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  busy_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o);

  // R6
  wt_issues_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK && q_write && q_shared && !(tag_hit && t_shared_i != q_shared))
      |=> (mem_req_valid_o && mem_req_write_o && mem_req_addr_o == $past(q_addr)));
endmodule

// File: rtl/sinv_dcache.sv
module sinv_dcache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_shared_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              sync_i,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx, clr_idx;
  logic              t_valid, t_dirty, t_shared;
  logic [TAG_W-1:0]  t_tag, t_wtag;
  logic              t_we, t_wvalid, t_wdirty, t_wshared, t_clr;
  logic              d_we;
  logic [DATA_W-1:0] d_wdata, d_rdata;

  sinv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_write_i, .req_shared_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o, .sync_i, .busy_o,
    .mem_req_valid_o, .mem_req_write_o, .mem_req_addr_o, .mem_req_wdata_o,
    .mem_rsp_valid_i, .mem_rsp_rdata_i,
    .idx_o(idx), .t_valid_i(t_valid), .t_dirty_i(t_dirty), .t_shared_i(t_shared),
    .t_tag_i(t_tag), .t_we_o(t_we), .t_wvalid_o(t_wvalid), .t_wdirty_o(t_wdirty),
    .t_wshared_o(t_wshared), .t_wtag_o(t_wtag), .t_clr_o(t_clr), .t_clr_idx_o(clr_idx),
    .d_we_o(d_we), .d_wdata_o(d_wdata), .d_rdata_i(d_rdata)
  );

  sinv_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(idx),
    .rd_valid_o(t_valid), .rd_dirty_o(t_dirty), .rd_shared_o(t_shared), .rd_tag_o(t_tag),
    .we_i(t_we), .wvalid_i(t_wvalid), .wdirty_i(t_wdirty), .wshared_i(t_wshared),
    .wtag_i(t_wtag), .clr_i(t_clr), .clr_idx_i(clr_idx)
  );

  sinv_data_store #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
    .clk_i, .idx_i(idx), .we_i(d_we), .wdata_i(d_wdata), .rdata_o(d_rdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!mem_req_valid_o && !busy_o));
endmodule

// File: tb/sinv_dcache_test.sv
module sinv_dcache_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SETS   = 16;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_write = 0, req_shared = 0, sync = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid, busy;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid = 0;
  logic [DATA_W-1:0] mem_rsp_rdata = '0;

  sinv_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_shared_i(req_shared), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sync_i(sync), .busy_o(busy),
    .mem_req_valid_o(mem_req_valid), .mem_req_write_o(mem_req_write),
    .mem_req_addr_o(mem_req_addr), .mem_req_wdata_o(mem_req_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_rdata_i(mem_rsp_rdata)
  );

  logic [DATA_W-1:0] mem   [MEMSZ];
  logic [DATA_W-1:0] view  [MEMSZ];
  logic [DATA_W-1:0] pendv [MEMSZ];
  bit                pendf [MEMSZ];
  bit                log_w [16];
  int                log_a [16];
  logic [DATA_W-1:0] log_d [16];
  int tr_n = 0, lat = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // lower level: answers each request after 3 cycles
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 0;
      lat <= 0;
    end else if (mem_req_valid && !mem_rsp_valid) begin
      if (lat == 2) begin
        mem_rsp_valid <= 1;
        lat <= 0;
        mem_rsp_rdata <= mem[mem_req_addr];
        if (mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
        log_w[tr_n & 15] <= mem_req_write;
        log_a[tr_n & 15] <= int'(mem_req_addr);
        log_d[tr_n & 15] <= mem_req_wdata;
        tr_n <= tr_n + 1;
      end else lat <= lat + 1;
    end else mem_rsp_valid <= 0;
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int a, input logic [DATA_W-1:0] d, input bit sh,
                        output logic [DATA_W-1:0] rd, output int ntr);
    int t0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d; req_shared = sh;
    while (!req_ready) @(negedge clk);
    t0 = tr_n;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    ntr = tr_n - t0;
    if (wr) view[a] = d;
  endtask

  task automatic agent_write(input int a, input logic [DATA_W-1:0] d);
    mem[a] = d;
    pendv[a] = d;
    pendf[a] = 1;
  endtask

  task automatic do_sync(output int bcyc);
    @(negedge clk);
    sync = 1;
    @(negedge clk);
    sync = 0;
    bcyc = 0;
    while (busy) begin
      bcyc++;
      @(negedge clk);
    end
    for (int i = 0; i < MEMSZ; i++) if (pendf[i]) begin
      view[i] = pendv[i];
      pendf[i] = 0;
    end
  endtask

  function automatic logic [DATA_W-1:0] init_val(int i);
    return DATA_W'(i) * 32'h0101_0101 ^ 32'hA5A5_0000;
  endfunction

  initial begin
    logic [DATA_W-1:0] rd;
    int nt, bc, t0, stall_bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = init_val(i);
      view[i] = mem[i];
      pendf[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !busy && !mem_req_valid && !rsp_valid, "R1", "idle after reset",
        {req_ready, busy, mem_req_valid, rsp_valid}, 4'b1000);

    // R3 load miss, R2 hit
    access(0, 5, 0, 0, rd, nt);
    chk(rd == init_val(5) && nt == 1, "R3", "miss fill", rd, init_val(5));
    access(0, 5, 0, 0, rd, nt);
    chk(rd == init_val(5) && nt == 0, "R2", "hit no traffic", rd, init_val(5));

    // R4 private store stays in cache
    access(1, 5, 32'h1111_0005, 0, rd, nt);
    chk(nt == 0, "R4", "private store traffic", nt, 0);
    chk(mem[5] == init_val(5), "R4", "lower level untouched", mem[5], init_val(5));
    access(0, 5, 0, 0, rd, nt);
    chk(rd == 32'h1111_0005 && nt == 0, "R4", "read own store", rd, 32'h1111_0005);

    // R5 conflicting miss: write-back then fill
    t0 = tr_n;
    access(0, 5 + SETS, 0, 0, rd, nt);
    chk(nt == 2, "R5", "two transactions", nt, 2);
    chk(log_w[t0 & 15] && log_a[t0 & 15] == 5 && log_d[t0 & 15] == 32'h1111_0005,
        "R5", "write-back first", log_d[t0 & 15], 32'h1111_0005);
    chk(!log_w[(t0 + 1) & 15] && log_a[(t0 + 1) & 15] == 5 + SETS, "R5", "fill second",
        log_a[(t0 + 1) & 15], 5 + SETS);
    chk(rd == init_val(5 + SETS), "R5", "fill data", rd, init_val(5 + SETS));

    // R4 write-allocate on private miss
    access(1, 7, 32'h7777_0007, 0, rd, nt);
    chk(nt == 0, "R4", "allocate no traffic", nt, 0);
    access(0, 7, 0, 0, rd, nt);
    chk(rd == 32'h7777_0007 && nt == 0, "R4", "allocated hit", rd, 32'h7777_0007);

    // R6 shared store miss: write-through, no allocate
    t0 = tr_n;
    access(1, 9, 32'h9999_0001, 1, rd, nt);
    chk(nt == 1 && log_w[t0 & 15] && log_a[t0 & 15] == 9 && log_d[t0 & 15] == 32'h9999_0001,
        "R6", "write-through miss", log_d[t0 & 15], 32'h9999_0001);
    access(0, 9, 0, 1, rd, nt);
    chk(nt == 1 && rd == 32'h9999_0001, "R6", "no allocate then fill", rd, 32'h9999_0001);
    access(1, 9, 32'h9999_0002, 1, rd, nt);
    chk(nt == 1 && mem[9] == 32'h9999_0002, "R6", "write-through hit", mem[9], 32'h9999_0002);
    access(0, 9, 0, 1, rd, nt);
    chk(nt == 0 && rd == 32'h9999_0002, "R6", "resident copy updated", rd, 32'h9999_0002);

    // R7 foreign write seen only after sync
    agent_write(9, 32'hABCD_0009);
    access(0, 9, 0, 1, rd, nt);
    chk(nt == 0 && rd == 32'h9999_0002, "R7", "stale before sync", rd, 32'h9999_0002);
    do_sync(bc);
    chk(bc == SETS, "R8", "busy duration", bc, SETS);
    access(0, 9, 0, 1, rd, nt);
    chk(nt == 1 && rd == 32'hABCD_0009, "R7", "fresh after sync", rd, 32'hABCD_0009);
    access(0, 7, 0, 0, rd, nt);
    chk(nt == 0 && rd == 32'h7777_0007, "R7", "private kept", rd, 32'h7777_0007);

    // R6 clean shared eviction
    access(0, 9 + SETS, 0, 0, rd, nt);
    chk(nt == 1 && rd == init_val(9 + SETS), "R6", "no write-back of shared", nt, 1);

    // R9 classification flip on dirty private line
    t0 = tr_n;
    access(0, 7, 0, 1, rd, nt);
    chk(nt == 2 && log_w[t0 & 15] && log_a[t0 & 15] == 7, "R9", "flush before refetch", nt, 2);
    chk(rd == 32'h7777_0007 && mem[7] == 32'h7777_0007, "R9", "data kept", rd, 32'h7777_0007);

    // R8 request held off during walk
    @(negedge clk);
    sync = 1;
    @(negedge clk);
    sync = 0;
    req_valid = 1; req_write = 0; req_addr = ADDR_W'(7); req_shared = 0;
    stall_bad = 0;
    while (busy) begin
      if (req_ready) stall_bad++;
      @(negedge clk);
    end
    chk(stall_bad == 0, "R8", "no accept while busy", stall_bad, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 32'h7777_0007, "R11", "response after walk", rsp_rdata, 32'h7777_0007);
    @(negedge clk);
    chk(!rsp_valid, "R11", "single pulse", rsp_valid, 0);

    // random mix against the view model
    for (int k = 0; k < 600; k++) begin
      int a, op;
      bit sh;
      logic [DATA_W-1:0] d;
      a = int'($urandom_range(0, 63));
      sh = a[4];
      op = int'($urandom_range(0, 9));
      d = $urandom;
      if (op < 5) begin
        access(0, a, 0, sh, rd, nt);
        chk(rd == view[a], "R3", "random load", rd, view[a]);
      end else if (op < 8) begin
        t0 = tr_n;
        access(1, a, d, sh, rd, nt);
        if (sh)
          chk(nt == 1 && log_a[t0 & 15] == a && log_d[t0 & 15] == d, "R6",
              "random write-through", log_d[t0 & 15], d);
      end else if (op == 8) begin
        a = a | 16;
        agent_write(a, d);
        do_sync(bc);
        chk(bc == SETS, "R8", "random sync duration", bc, SETS);
      end else begin
        do_sync(bc);
      end
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule